// File: doc/BRIEF.md
# Serial EEPROM configuration loader

This block fills a device's identity and option registers from a small serial configuration EEPROM. It runs on its own once reset is released, and again whenever software asks for a reload. It reads a fixed image one byte at a time through a request/response port. A signature at byte 0 decides whether the image is used at all. Bytes 1 to 6 form the MAC address, which goes to both a host copy and a switch copy. A second signature at byte 7 decides whether bytes 8 to 11 replace the configuration-strap register. The loader always finishes a full run by writing strap-derived values into three PHY registers for each port through a write-strobe port.

Once a run ends, the loader sits in a wait state with `busy` low. A host soft reset seen there starts a short run. That run reads the signature and the six MAC bytes only, and updates only the host copy of the address.

The EEPROM request channel uses valid/ready. `req_valid` and `req_addr` stay fixed until the handshake, and only one request is outstanding at a time. The response channel has no ready signal. The loader accepts `rsp_valid` in any cycle while a request is outstanding and ignores it in every other cycle. The PHY strobe has no back-pressure.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset is released, `busy` is high and a full run starts from byte 0 with no command. A `reload_cmd` seen in the wait state starts another full run on the next clock.
- R2: If byte 0 is not A5h, a full run issues no request after byte 0. It leaves both MAC outputs and `strap_cfg` unchanged, performs the PHY writes, and then drops `busy`.
- R3: If byte 0 is A5h, bytes 1 to 6 are loaded into both `host_mac` and `switch_mac`. Byte 1 goes to bits 7:0 and byte 6 to bits 47:40. Both copies change together, after byte 6 arrives.
- R4: If byte 7 is A5h, bytes 8 to 11 are written into `strap_cfg`. Byte 8 goes to bits 7:0 and byte 11 to bits 31:24.
- R5: If byte 7 is not A5h, bytes 8 to 11 are still requested, so a run reads 12 bytes, but `strap_cfg` keeps its old value.
- R6: A full run ends with six `phy_we` strobes on consecutive cycles, for port 1 then port 2, each in the order register 4, register 18, register 0. Port p uses strap byte p-1 (bits 8p-1:8p-8), in which bit 0 means autoneg, bit 1 full duplex, bit 2 speed 100 and bit 6 pause.
  - Register 0 gets speed at bit 13, autoneg at bit 12 and duplex at bit 8.
  - Register 4 gets pause at bit 10, speed&duplex at bit 8, speed at bit 7, duplex at bit 6, and bits 5 and 0 set.
  - Register 18 gets bits 7:5 = 111b when autoneg is set, or {0, speed, duplex} when it is not, and bits 4:0 = the port number.
- R7: A `host_soft_rst` seen in the wait state reads bytes 0 to 6 only. It updates `host_mac` when byte 0 is A5h, and leaves `switch_mac` and `strap_cfg` unchanged with no PHY writes.
- R8: A soft-reset run whose byte 0 is not A5h issues exactly one request and changes no output register.
- R9: `busy` is high from the cycle after a trigger until the last PHY strobe (or the end of a short run), and is low in the wait state. No request is issued while `busy` is low.
- R10: A response with `rsp_err` set ends the run at once with `busy` low and no PHY writes. An address not yet complete is never written.
- R11: `reload_cmd` and `host_soft_rst` are ignored while `busy` is high; no extra run follows.
- R12: Requests use addresses 0, 1, 2, … in order, one outstanding at a time. `req_addr` holds while `req_valid` waits for `req_ready`.
- R13: If `reload_cmd` and `host_soft_rst` arrive in the same wait cycle, the full run wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the loader starts when it is released |
| reload_cmd | input | 1 | Software request for a full run |
| host_soft_rst | input | 1 | Host soft reset; requests the host-MAC-only run |
| req_valid | output | 1 | EEPROM byte request valid |
| req_ready | input | 1 | EEPROM port accepts the request |
| req_addr | output | ADDR_W | EEPROM byte address |
| rsp_valid | input | 1 | Response byte valid |
| rsp_data | input | 8 | Response byte |
| rsp_err | input | 1 | Response carries an error or timeout |
| busy | output | 1 | Loader active |
| host_mac | output | 8*MAC_BYTES | Host copy of the MAC address |
| switch_mac | output | 8*MAC_BYTES | Switch copy of the MAC address |
| strap_cfg | output | 8*STRAP_BYTES | Configuration-strap register |
| phy_we | output | 1 | PHY register write strobe |
| phy_port | output | $clog2(PHY_PORTS+1) | PHY port number, starting at 1 |
| phy_reg | output | 5 | PHY register index |
| phy_wdata | output | 16 | PHY register value |

## Verification
The hardest cases to reach from the ports involve timing inside a run. One is an error response that lands partway through the MAC bytes. Another is a command that arrives while a run is in progress. The bench's EEPROM model injects an error at a chosen byte address and can withhold `req_ready` on two cycles out of three. Commands are pulsed a fixed number of cycles after a reload, so they fall mid-run. A fresh image is loaded before each case, so any partial write or any extra run shows up in the final register values and in the log of requested addresses.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [1:0] {LD_WAIT, LD_ISSUE, LD_FETCH, LD_PHY} ld_state_e;
  typedef enum logic [1:0] {FT_IDLE, FT_REQ, FT_RSP} ft_state_e;
  localparam logic [4:0] PHYREG_CTRL  = 5'd0;
  localparam logic [4:0] PHYREG_ADV   = 5'd4;
  localparam logic [4:0] PHYREG_SMODE = 5'd18;
endpackage

// File: rtl/phy_word_enc.sv
module phy_word_enc #(
  parameter int PORT_NUM = 1
) (
  input  logic [7:0]  strap_byte,
  output logic [15:0] w_adv,
  output logic [15:0] w_smode,
  output logic [15:0] w_ctrl
);
  logic an, dx, sp, pz;
  logic [2:0] mode3;

  assign an = strap_byte[0];
  assign dx = strap_byte[1];
  assign sp = strap_byte[2];
  assign pz = strap_byte[6];
  assign mode3 = an ? 3'b111 : {1'b0, sp, dx};

  assign w_ctrl  = {2'b00, sp, an, 3'b000, dx, 8'h00};
  assign w_adv   = {5'b00000, pz, 1'b0, sp & dx, sp, dx, 1'b1, 5'b00001};
  assign w_smode = {8'h00, mode3, 5'(PORT_NUM)};
endmodule

// File: rtl/byte_fetcher.sv
module byte_fetcher
  import cfg_loader_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  input  logic              rsp_err,
  output logic              got,
  output logic              got_err,
  output logic [7:0]        got_data
);
  ft_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FT_IDLE;
      req_addr <= '0;
    end else begin
      case (st)
        FT_IDLE: if (go) begin
          st       <= FT_REQ;
          req_addr <= go_addr;
        end
        FT_REQ:  if (req_ready) st <= FT_RSP;
        FT_RSP:  if (rsp_valid) st <= FT_IDLE;
        default: st <= FT_IDLE;
      endcase
    end
  end

  assign req_valid = (st == FT_REQ);
  assign got       = (st == FT_RSP) && rsp_valid;
  assign got_err   = rsp_err;
  assign got_data  = rsp_data;

  // R12: a waiting request keeps its address
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
  // R12: no new request while a response is outstanding
  p_single_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfg_loader_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          MAC_BYTES   = 6,
  parameter int          STRAP_BYTES = 4,
  parameter int          PHY_PORTS   = 2,
  parameter logic [7:0]  SIG         = 8'hA5,
  parameter logic [31:0] STRAP_RESET = 32'h0000_0101
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reload_cmd,
  input  logic                       host_soft_rst,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic [ADDR_W-1:0]          req_addr,
  input  logic                       rsp_valid,
  input  logic [7:0]                 rsp_data,
  input  logic                       rsp_err,
  output logic                       busy,
  output logic [8*MAC_BYTES-1:0]     host_mac,
  output logic [8*MAC_BYTES-1:0]     switch_mac,
  output logic [8*STRAP_BYTES-1:0]   strap_cfg,
  output logic                       phy_we,
  output logic [$clog2(PHY_PORTS+1)-1:0] phy_port,
  output logic [4:0]                 phy_reg,
  output logic [15:0]                phy_wdata
);
  localparam int IDX_FLAG = MAC_BYTES + 1;
  localparam int IDX_LAST = IDX_FLAG + STRAP_BYTES;
  localparam int IDX_W    = $clog2(IDX_LAST + 1);
  localparam int PIX_W    = (PHY_PORTS > 1) ? $clog2(PHY_PORTS) : 1;
  localparam int PN_W     = $clog2(PHY_PORTS + 1);
  localparam logic [IDX_W-1:0] I_MACEND = IDX_W'(MAC_BYTES);
  localparam logic [IDX_W-1:0] I_FLAG   = IDX_W'(IDX_FLAG);
  localparam logic [IDX_W-1:0] I_LAST   = IDX_W'(IDX_LAST);
  localparam logic [PIX_W-1:0] P_LAST   = PIX_W'(PHY_PORTS - 1);

  ld_state_e                  st;
  logic [IDX_W-1:0]           idx;
  logic                       full_q, strap_ok_q;
  logic [8*MAC_BYTES-1:0]     mac_stage, stage_nx, host_q, sw_q;
  logic [8*STRAP_BYTES-1:0]   strap_q, strap_nx;
  logic [PIX_W-1:0]           port_ix;
  logic [1:0]                 sel_ix;
  logic                       f_go, f_got, f_err;
  logic [7:0]                 f_data;

  byte_fetcher #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(f_go), .go_addr(ADDR_W'(idx)),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .got(f_got), .got_err(f_err), .got_data(f_data)
  );

  assign f_go = (st == LD_ISSUE);

  // byte merge for the MAC staging register and the strap register
  always_comb begin
    stage_nx = mac_stage;
    for (int k = 0; k < MAC_BYTES; k++)
      if (idx == IDX_W'(k + 1)) stage_nx[8*k +: 8] = f_data;
    strap_nx = strap_q;
    for (int k = 0; k < STRAP_BYTES; k++)
      if (idx == IDX_W'(IDX_FLAG + 1 + k)) strap_nx[8*k +: 8] = f_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= LD_ISSUE;
      idx        <= '0;
      full_q     <= 1'b1;
      strap_ok_q <= 1'b0;
      mac_stage  <= '0;
      host_q     <= '0;
      sw_q       <= '0;
      strap_q    <= (8*STRAP_BYTES)'(STRAP_RESET);
      port_ix    <= '0;
      sel_ix     <= '0;
    end else begin
      case (st)
        LD_WAIT: begin
          if (reload_cmd || host_soft_rst) begin
            full_q     <= reload_cmd;
            idx        <= '0;
            strap_ok_q <= 1'b0;
            st         <= LD_ISSUE;
          end
        end
        LD_ISSUE: st <= LD_FETCH;
        LD_FETCH: if (f_got) begin
          if (f_err) begin
            st <= LD_WAIT;
          end else begin
            mac_stage <= stage_nx;
            idx       <= idx + IDX_W'(1);
            st        <= LD_ISSUE;
            if (idx == '0 && f_data != SIG) begin
              st      <= full_q ? LD_PHY : LD_WAIT;
              port_ix <= '0;
              sel_ix  <= '0;
            end
            if (idx == I_MACEND) begin
              host_q <= stage_nx;
              if (full_q) sw_q <= stage_nx;
              if (!full_q) st <= LD_WAIT;
            end
            if (idx == I_FLAG) strap_ok_q <= (f_data == SIG);
            if (strap_ok_q) strap_q <= strap_nx;
            if (idx == I_LAST) begin
              st      <= LD_PHY;
              port_ix <= '0;
              sel_ix  <= '0;
            end
          end
        end
        LD_PHY: begin
          if (sel_ix == 2'd2) begin
            sel_ix <= '0;
            if (port_ix == P_LAST) st <= LD_WAIT;
            else port_ix <= port_ix + PIX_W'(1);
          end else begin
            sel_ix <= sel_ix + 2'd1;
          end
        end
        default: st <= LD_WAIT;
      endcase
    end
  end

  // per-port PHY word encoders
  logic [15:0] w_adv [PHY_PORTS];
  logic [15:0] w_sm  [PHY_PORTS];
  logic [15:0] w_ct  [PHY_PORTS];

  for (genvar gp = 0; gp < PHY_PORTS; gp++) begin : g_enc
    phy_word_enc #(.PORT_NUM(gp + 1)) u_enc (
      .strap_byte(strap_q[8*gp +: 8]),
      .w_adv(w_adv[gp]), .w_smode(w_sm[gp]), .w_ctrl(w_ct[gp])
    );
  end

  always_comb begin
    case (sel_ix)
      2'd0:    begin phy_reg = PHYREG_ADV;   phy_wdata = w_adv[port_ix]; end
      2'd1:    begin phy_reg = PHYREG_SMODE; phy_wdata = w_sm[port_ix];  end
      default: begin phy_reg = PHYREG_CTRL;  phy_wdata = w_ct[port_ix];  end
    endcase
  end

  assign phy_we     = (st == LD_PHY);
  assign phy_port   = PN_W'(port_ix) + PN_W'(1);
  assign busy       = (st != LD_WAIT);
  assign host_mac   = host_q;
  assign switch_mac = sw_q;
  assign strap_cfg  = strap_q;

  // R6 / R9: PHY strobes only inside an active run
  p_phy_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_we |-> busy);
  // R9: idle loader issues no request
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
  // R1: reload in the wait state starts a full run
  p_reload_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reload_cmd) |=> (busy && full_q));
  // R7: a short run never touches the switch copy
  p_switch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !full_q) |=> $stable(switch_mac));
  // R5: straps move only after a valid flag byte
  p_strap_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_ok_q |=> $stable(strap_cfg));
  // R11: run kind cannot change while busy
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(full_q)));
endmodule

// File: tb/cfg_image_loader_test.sv
`timescale 1ns/1ps
module cfg_image_loader_test;
  logic        clk = 1'b0;
  logic        rst_n, reload_cmd, host_soft_rst;
  logic        req_valid, req_ready, rsp_valid, rsp_err;
  logic [7:0]  req_addr, rsp_data;
  logic        busy, phy_we;
  logic [47:0] host_mac, switch_mac;
  logic [31:0] strap_cfg;
  logic [1:0]  phy_port;
  logic [4:0]  phy_reg;
  logic [15:0] phy_wdata;

  always #2 clk = ~clk;

  cfg_image_loader uut (
    .clk(clk), .rst_n(rst_n), .reload_cmd(reload_cmd), .host_soft_rst(host_soft_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .busy(busy), .host_mac(host_mac), .switch_mac(switch_mac), .strap_cfg(strap_cfg),
    .phy_we(phy_we), .phy_port(phy_port), .phy_reg(phy_reg), .phy_wdata(phy_wdata)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] mem [16];
  int err_addr = -1;
  bit stall = 0;
  int cyc = 0, nrd = 0, nphy = 0;
  logic [7:0]  rd_log [32];
  logic [1:0]  pp_log [8];
  logic [4:0]  pr_log [8];
  logic [15:0] pd_log [8];
  int          pc_log [8];
  logic [47:0] exp_host, exp_sw;
  logic [31:0] exp_strap;

  // EEPROM model and monitor
  initial begin
    bit pend = 0;
    logic [7:0] pa = '0;
    req_ready = 1'b1; rsp_valid = 1'b0; rsp_data = '0; rsp_err = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      req_ready = stall ? (cyc % 3 == 0) : 1'b1;
      if (pend) begin
        rsp_valid = 1'b1; rsp_data = mem[pa[3:0]];
        rsp_err = (int'(pa) == err_addr); pend = 0;
      end else begin
        rsp_valid = 1'b0; rsp_data = '0; rsp_err = 1'b0;
      end
      if (req_valid && req_ready) begin
        pend = 1; pa = req_addr;
        if (nrd < 32) rd_log[nrd] = req_addr;
        nrd++;
      end
      if (phy_we) begin
        if (nphy < 8) begin
          pp_log[nphy] = phy_port; pr_log[nphy] = phy_reg;
          pd_log[nphy] = phy_wdata; pc_log[nphy] = cyc;
        end
        nphy++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(logic [7:0] b, int sel, int port);
    logic an, dx, sp, pz;
    an = b[0]; dx = b[1]; sp = b[2]; pz = b[6];
    if (sel == 0) return 16'h0021 | (16'(pz) << 10) | (16'(sp & dx) << 8) | (16'(sp) << 7) | (16'(dx) << 6);
    if (sel == 1) return (an ? 16'h00E0 : ((16'(sp) << 6) | (16'(dx) << 5))) | 16'(port);
    return (16'(sp) << 13) | (16'(an) << 12) | (16'(dx) << 8);
  endfunction

  task automatic load_image(input logic [7:0] b0, input logic [7:0] b7,
                            input logic [47:0] mac, input logic [31:0] st);
    for (int k = 0; k < 16; k++) mem[k] = 8'h00;
    mem[0] = b0; mem[7] = b7;
    for (int k = 0; k < 6; k++) mem[1+k] = mac[8*k +: 8];
    for (int k = 0; k < 4; k++) mem[8+k] = st[8*k +: 8];
  endtask

  task automatic clear_logs();
    nrd = 0; nphy = 0;
  endtask

  task automatic pulse(input bit rl, input bit sr);
    @(negedge clk); reload_cmd = rl; host_soft_rst = sr;
    @(negedge clk); reload_cmd = 1'b0; host_soft_rst = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy && t < 3000) begin @(negedge clk); t++; end
    chk({tag, " run ends"}, 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_reads(input string tag, input int n);
    chk({tag, " read count"}, 64'(nrd), 64'(n));
    for (int i = 0; i < n && i < 32; i++)
      chk({tag, " R12 address order"}, 64'(rd_log[i]), 64'(i));
  endtask

  task automatic chk_phy(input string tag, input logic [31:0] st);
    chk({tag, " R6 write count"}, 64'(nphy), 64'd6);
    for (int i = 0; i < 6 && i < nphy; i++) begin
      int p = i / 3, s = i % 3;
      chk({tag, " R6 port"}, 64'(pp_log[i]), 64'(p + 1));
      chk({tag, " R6 reg"}, 64'(pr_log[i]), (s == 0) ? 64'd4 : (s == 1) ? 64'd18 : 64'd0);
      chk({tag, " R6 data"}, 64'(pd_log[i]), 64'(exp_word(st[8*p +: 8], s, p + 1)));
      chk({tag, " R6 consecutive"}, 64'(pc_log[i]), 64'(pc_log[0] + i));
    end
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " host mac"}, 64'(host_mac), 64'(exp_host));
    chk({tag, " switch mac"}, 64'(switch_mac), 64'(exp_sw));
    chk({tag, " straps"}, 64'(strap_cfg), 64'(exp_strap));
  endtask

  // {stall, byte0, byte7, mac, straps}
  localparam int NV = 4;
  localparam logic [96:0] VECS [NV] = '{
    {1'b0, 8'hA5, 8'hA5, 48'h0A1B2C3D4E5F, 32'h33224605},
    {1'b1, 8'hA5, 8'h5A, 48'h112233445566, 32'hFFFFFFFF},
    {1'b0, 8'h00, 8'hA5, 48'hDEADBEEF0001, 32'h01020304},
    {1'b1, 8'hA5, 8'hA5, 48'h665544332211, 32'h8C4A0702}
  };

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; reload_cmd = 1'b0; host_soft_rst = 1'b0;
    load_image(8'hA5, 8'hA5, 48'h00AA00BB00CC, 32'h00000641);
    repeat (5) @(negedge clk);
    clear_logs();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd1);
    wait_idle("R1 boot");
    exp_host = 48'h00AA00BB00CC; exp_sw = exp_host; exp_strap = 32'h00000641;
    chk_regs("R1 R3 R4 boot");
    chk_reads("R1 boot", 12);
    chk_phy("R1 boot", exp_strap);

    // table of full runs
    for (int v = 0; v < NV; v++) begin
      logic [96:0] e = VECS[v];
      stall = e[96];
      load_image(e[95:88], e[87:80], e[79:32], e[31:0]);
      clear_logs();
      pulse(1'b1, 1'b0);
      chk("R9 busy during run", 64'(busy), 64'd1);
      wait_idle("R9 table");
      if (e[95:88] == 8'hA5) begin
        exp_host = e[79:32]; exp_sw = e[79:32];
        if (e[87:80] == 8'hA5) exp_strap = e[31:0];
        chk_reads("R5 table", 12);
      end else begin
        chk_reads("R2 table", 1);
      end
      chk_regs("R2 R3 R4 R5 table");
      chk_phy("R6 table", exp_strap);
    end
    stall = 0;

    // soft reset with valid signature: host only
    load_image(8'hA5, 8'hA5, 48'h123456789ABC, 32'h00000000);
    clear_logs();
    pulse(1'b0, 1'b1);
    wait_idle("R7 soft");
    exp_host = 48'h123456789ABC;
    chk_regs("R7 soft");
    chk_reads("R7 soft", 7);
    chk("R7 no phy writes", 64'(nphy), 64'd0);

    // soft reset with bad signature
    load_image(8'h3C, 8'hA5, 48'h999999999999, 32'h00000000);
    clear_logs();
    pulse(1'b0, 1'b1);
    wait_idle("R8 soft bad");
    chk_regs("R8 soft bad");
    chk_reads("R8 soft bad", 1);
    chk("R8 no phy writes", 64'(nphy), 64'd0);

    // error mid-MAC
    load_image(8'hA5, 8'hA5, 48'hCAFEF00D1234, 32'h00000000);
    err_addr = 3;
    clear_logs();
    pulse(1'b1, 1'b0);
    wait_idle("R10 error");
    chk_regs("R10 error");
    chk_reads("R10 error", 4);
    chk("R10 no phy writes", 64'(nphy), 64'd0);
    err_addr = -1;

    // commands while busy ignored
    load_image(8'hA5, 8'h00, 48'h0102030405A6, 32'h00000000);
    clear_logs();
    pulse(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    pulse(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    pulse(1'b1, 1'b0);
    wait_idle("R11 busy cmds");
    repeat (30) @(negedge clk);
    chk("R11 stays idle", 64'(busy), 64'd0);
    exp_host = 48'h0102030405A6; exp_sw = exp_host;
    chk_regs("R11 busy cmds");
    chk_reads("R11 busy cmds", 12);
    chk("R11 single phy sequence", 64'(nphy), 64'd6);

    // simultaneous reload and soft reset
    load_image(8'hA5, 8'hA5, 48'h77665544BEEF, 32'h00000207);
    clear_logs();
    pulse(1'b1, 1'b1);
    wait_idle("R13 both");
    exp_host = 48'h77665544BEEF; exp_sw = exp_host; exp_strap = 32'h00000207;
    chk_regs("R13 both");
    chk_reads("R13 both", 12);
    chk_phy("R13 both", exp_strap);

    summary();
  end
endmodule